// File: doc/BRIEF.md
# Serial Configuration Master

This block loads a bitstream into a programmable device through the device's serial configuration port. When a start command arrives, it drives the active-low program pin and takes the device through its initialisation handshake. It then shifts the configuration bytes out on a data pin and a generated configuration clock. The bytes come in over a valid/ready stream. The number of bytes to load is captured when the start command is accepted.

The target's status pins are watched throughout. The init pin is active low and the done pin is active high. Before each byte, a fault on these pins stops the load with a CRC error. After the last byte, the data pin is held high and single clock pulses are issued until the target reports done. Each of the three waits has its own cycle-count limit, 10 ms at the system clock. Expiry of any limit, or a CRC fault, aborts the sequence and leaves a failure status that holds until the next start.

Top module: `sercfg_master`

## Requirements
- R1: Reset state. While reset is active and afterwards until a start: prog_n_o=1, cclk_o=0, din_o=0, byte_ready_o=0, and busy_o, ok_o, timeout_o and crc_err_o are all 0.
- R2: A start accepted while not busy drives prog_n_o low from the next cycle. prog_n_o returns high in the cycle after init_n_i is first sampled low.
- R3: Between the release of prog_n_o and the first cycle in which init_n_i is sampled high, byte_ready_o stays 0 and no cclk_o pulse is issued.
- R4: Each of the three waits (init_n_i low, init_n_i high, done_i high) lasts at most WAIT_CYCLES cycles from state entry. If the awaited condition is sampled in the last cycle of the window, it wins. Otherwise the block aborts with timeout_o=1.
- R5: Each byte goes out most significant bit first, with exactly eight rising edges of cclk_o. din_o is set at the start of each low phase and is stable while cclk_o is high. Each low phase and each high phase lasts CLK_DIV cycles.
- R6: byte_ready_o is 1 only in the data phase, while no bit is being shifted, and while fewer than the programmed number of bytes have been taken. A byte is taken on a cycle with byte_valid_i=1 and byte_ready_o=1.
- R7: Before each byte, if init_n_i=0 and done_i=0, the load stops with crc_err_o=1 and no byte is taken. With done_i=1, init_n_i=0 is not a fault.
- R8: Once all bytes have been shifted, din_o is held high during single cclk_o pulses. The sequence ends with ok_o=1 when done_i is sampled high between pulses.
- R9: After an abort: prog_n_o=1, cclk_o=0, din_o=0 and busy_o=0. Exactly one of timeout_o and crc_err_o is 1, and it holds until the next start.
- R10: A length of zero goes straight from the handshake to the done wait, with no data clocks.
- R11: A start command is ignored while busy_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a configuration sequence |
| length_i | input | LEN_W | Number of bytes to load, captured on start |
| byte_data_i | input | 8 | Configuration byte |
| byte_valid_i | input | 1 | Byte present on byte_data_i |
| byte_ready_o | output | 1 | Block takes the byte this cycle if valid |
| init_n_i | input | 1 | Target init status pin, active low |
| done_i | input | 1 | Target done status pin |
| prog_n_o | output | 1 | Target program pin, active low |
| cclk_o | output | 1 | Configuration clock to the target |
| din_o | output | 1 | Configuration serial data |
| busy_o | output | 1 | Sequence in progress |
| ok_o | output | 1 | Last sequence completed with done seen |
| timeout_o | output | 1 | Last sequence aborted by a wait limit |
| crc_err_o | output | 1 | Last sequence aborted by a load fault |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a wait reaching its final cycle while the awaited pin change arrives. The second is done rising while the done-wait limit runs out. The bench drops init_n_i on exactly the cycle that the window's last sample takes, and again one cycle later. The first run must advance and the second must abort with a timeout. A behavioural reference model, stepped every clock, decides the expected outcome of each of these races. The model independently gives priority to the pin condition. A further case raises init_n_i low with done_i high between bytes, to show that a fault needs both pins.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PROG  = 3'd1,
    ST_WAKE  = 3'd2,
    ST_LOAD  = 3'd3,
    ST_FLUSH = 3'd4,
    ST_OK    = 3'd5,
    ST_FAIL  = 3'd6
  } sercfg_state_e;

  // A load fault: target pulls init low while it has not reported done.
  function automatic logic f_crc_fault(input logic init_n, input logic done);
    return (!init_n) && (!done);
  endfunction

  // Last cycle of a window of `span` cycles counted from zero.
  function automatic logic f_last_of(input logic [31:0] count, input logic [31:0] span);
    return count == (span - 32'd1);
  endfunction

  // States in which a wait limit is running.
  function automatic logic f_is_wait(input sercfg_state_e s);
    return (s == ST_PROG) || (s == ST_WAKE) || (s == ST_FLUSH);
  endfunction

  function automatic logic f_is_busy(input sercfg_state_e s);
    return (s == ST_PROG) || (s == ST_WAKE) || (s == ST_LOAD) || (s == ST_FLUSH);
  endfunction

endpackage

// File: rtl/sercfg_divider.sv
module sercfg_divider #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  output logic tick_o
);
  import sercfg_pkg::*;

  generate
    if (CLK_DIV <= 1) begin : g_nodiv
      logic unused_restart;
      assign unused_restart = restart_i;
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(CLK_DIV);
      logic [CW-1:0] cnt_q;
      assign tick_o = f_last_of(32'(cnt_q), CLK_DIV);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (restart_i || tick_o)  cnt_q <= '0;
        else                           cnt_q <= cnt_q + CW'(1);
      end
    end
  endgenerate

endmodule

// File: rtl/sercfg_timer.sv
module sercfg_timer #(
  parameter int unsigned LIMIT = 1000000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  output logic expired_o
);
  import sercfg_pkg::*;

  localparam int unsigned TW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  logic [TW-1:0] cnt_q;

  assign expired_o = f_last_of(32'(cnt_q), LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (clear_i)   cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + TW'(1);
  end

  a_r4_window_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    expired_o |=> (clear_i == 1'b0) || (cnt_q == '0) || expired_o);

endmodule

// File: rtl/sercfg_shifter.sv
module sercfg_shifter #(
  parameter int unsigned CLK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] load_byte_i,
  input  logic [3:0] load_bits_i,
  input  logic       abort_i,
  output logic       idle_o,
  output logic       cclk_o,
  output logic       din_o
);
  logic       tick_w;
  logic       busy_q, high_q, cclk_q, din_q;
  logic [3:0] left_q;
  logic [7:0] sreg_q;

  sercfg_divider #(.CLK_DIV(CLK_DIV)) i_div (
    .clk(clk), .rst_n(rst_n), .restart_i(load_i), .tick_o(tick_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; high_q <= 1'b0; cclk_q <= 1'b0; din_q <= 1'b0;
      left_q <= '0;   sreg_q <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0; high_q <= 1'b0; cclk_q <= 1'b0; din_q <= 1'b0;
      left_q <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      high_q <= 1'b0;
      cclk_q <= 1'b0;
      din_q  <= load_byte_i[7];
      sreg_q <= {load_byte_i[6:0], 1'b0};
      left_q <= load_bits_i;
    end else if (busy_q && tick_w) begin
      if (!high_q) begin
        cclk_q <= 1'b1;
        high_q <= 1'b1;
        left_q <= left_q - 4'd1;
      end else begin
        cclk_q <= 1'b0;
        high_q <= 1'b0;
        if (left_q == 4'd0) begin
          busy_q <= 1'b0;
        end else begin
          din_q  <= sreg_q[7];
          sreg_q <= {sreg_q[6:0], 1'b0};
        end
      end
    end
  end

  assign idle_o = !busy_q;
  assign cclk_o = cclk_q;
  assign din_o  = din_q;

  // R5: data is held steady while the clock is high
  a_r5_din_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    cclk_q |-> $stable(din_q));
  // R5: the clock moves only on a divided tick, a load or an abort
  a_r5_cclk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cclk_q) |-> $past(tick_w || abort_i || load_i));
  // R6: a load is only presented to an idle shifter
  a_r6_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !busy_q);

endmodule

// File: rtl/sercfg_master.sv
module sercfg_master #(
  parameter int unsigned CLK_DIV     = 4,
  parameter int unsigned WAIT_CYCLES = 1000000,
  parameter int unsigned LEN_W       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] length_i,
  input  logic [7:0]       byte_data_i,
  input  logic             byte_valid_i,
  output logic             byte_ready_o,
  input  logic             init_n_i,
  input  logic             done_i,
  output logic             prog_n_o,
  output logic             cclk_o,
  output logic             din_o,
  output logic             busy_o,
  output logic             ok_o,
  output logic             timeout_o,
  output logic             crc_err_o
);
  import sercfg_pkg::*;

  localparam logic [3:0] BYTE_BITS  = 4'd8;
  localparam logic [3:0] PULSE_BITS = 4'd1;
  localparam logic [7:0] FILL_BYTE  = 8'hFF;

  sercfg_state_e    state_q, state_d;
  logic [LEN_W-1:0] len_q, count_q;
  logic             tmo_q, crc_q;

  // named internal events
  logic       ev_start, ev_accept, ev_timeout, ev_crc, ev_abort;
  logic       sh_idle, sh_load, expired_w, timer_clear, fault_w, all_taken;
  logic [7:0] sh_byte;
  logic [3:0] sh_bits;

  assign fault_w   = f_crc_fault(init_n_i, done_i);
  assign all_taken = (count_q == len_q);

  always_comb begin
    state_d    = state_q;
    ev_start   = 1'b0;
    ev_accept  = 1'b0;
    ev_timeout = 1'b0;
    ev_crc     = 1'b0;
    sh_load    = 1'b0;
    sh_byte    = byte_data_i;
    sh_bits    = BYTE_BITS;
    unique case (state_q)
      ST_IDLE, ST_OK, ST_FAIL: begin
        if (start_i) begin
          state_d  = ST_PROG;
          ev_start = 1'b1;
        end
      end
      ST_PROG: begin
        if (!init_n_i)      state_d = ST_WAKE;
        else if (expired_w) begin state_d = ST_FAIL; ev_timeout = 1'b1; end
      end
      ST_WAKE: begin
        if (init_n_i)       state_d = ST_LOAD;
        else if (expired_w) begin state_d = ST_FAIL; ev_timeout = 1'b1; end
      end
      ST_LOAD: begin
        if (sh_idle) begin
          if (all_taken)          state_d = ST_FLUSH;
          else if (fault_w)       begin state_d = ST_FAIL; ev_crc = 1'b1; end
          else if (byte_valid_i)  begin sh_load = 1'b1; ev_accept = 1'b1; end
        end
      end
      ST_FLUSH: begin
        if (sh_idle && done_i) state_d = ST_OK;
        else if (expired_w)    begin state_d = ST_FAIL; ev_timeout = 1'b1; end
        else if (sh_idle) begin
          sh_load = 1'b1;
          sh_byte = FILL_BYTE;
          sh_bits = PULSE_BITS;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign ev_abort    = (state_d == ST_FAIL) && (state_q != ST_FAIL);
  assign timer_clear = !f_is_wait(state_q) || (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      count_q <= '0;
      tmo_q   <= 1'b0;
      crc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (ev_start) begin
        len_q   <= length_i;
        count_q <= '0;
        tmo_q   <= 1'b0;
        crc_q   <= 1'b0;
      end
      if (ev_accept)  count_q <= count_q + LEN_W'(1);
      if (ev_timeout) tmo_q   <= 1'b1;
      if (ev_crc)     crc_q   <= 1'b1;
    end
  end

  sercfg_timer #(.LIMIT(WAIT_CYCLES)) i_timer (
    .clk(clk), .rst_n(rst_n), .clear_i(timer_clear), .expired_o(expired_w)
  );

  sercfg_shifter #(.CLK_DIV(CLK_DIV)) i_shift (
    .clk(clk), .rst_n(rst_n),
    .load_i(sh_load), .load_byte_i(sh_byte), .load_bits_i(sh_bits),
    .abort_i(ev_abort),
    .idle_o(sh_idle), .cclk_o(cclk_o), .din_o(din_o)
  );

  assign byte_ready_o = (state_q == ST_LOAD) && sh_idle && !all_taken && !fault_w;
  assign prog_n_o     = (state_q != ST_PROG);
  assign busy_o       = f_is_busy(state_q);
  assign ok_o         = (state_q == ST_OK);
  assign timeout_o    = (state_q == ST_FAIL) && tmo_q;
  assign crc_err_o    = (state_q == ST_FAIL) && crc_q;

  // R2: prog is released right after init is seen low
  a_r2_prog_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!prog_n_o && !init_n_i) |=> prog_n_o);
  // R3: no data request and no clock while prog is driven
  a_r3_quiet_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n_o |-> (!byte_ready_o && !cclk_o));
  // R6: a ready request never coincides with a high clock
  a_r6_ready_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    byte_ready_o |-> !cclk_o);
  // R4: an expiry leaves a timeout status, not busy
  a_r4_timeout_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_timeout |=> (timeout_o && !busy_o));
  // R7: a load fault leaves the crc status
  a_r7_crc_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ev_crc |=> (crc_err_o && !timeout_o));
  // R8: data pin is high whenever a done-wait pulse is high
  a_r8_flush_din: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FLUSH && cclk_o) |-> din_o);
  // R9: aborted outputs are quiet and status is exclusive
  a_r9_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_o || crc_err_o) |-> (!cclk_o && !din_o && prog_n_o));
  a_r9_status_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy_o, ok_o, timeout_o, crc_err_o}));
  // R10: empty length skips the data phase
  a_r10_empty_len: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LOAD && len_q == '0) |=> (state_q == ST_FLUSH));
  // R11: a start while busy leaves the captured length alone
  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> $stable(len_q));

endmodule

// File: tb/test_sercfg_master.sv
module test_sercfg_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 2;
  localparam int WAIT = 40;
  localparam int LW   = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [LW-1:0] length_i = '0;
  logic [7:0]    byte_data_i = '0;
  logic          byte_valid_i = 1'b0;
  logic          byte_ready_o;
  logic          init_n_i = 1'b1;
  logic          done_i = 1'b0;
  logic          prog_n_o, cclk_o, din_o, busy_o, ok_o, timeout_o, crc_err_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sercfg_master #(.CLK_DIV(DIV), .WAIT_CYCLES(WAIT), .LEN_W(LW)) i_sercfg_master (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .length_i(length_i),
    .byte_data_i(byte_data_i), .byte_valid_i(byte_valid_i), .byte_ready_o(byte_ready_o),
    .init_n_i(init_n_i), .done_i(done_i), .prog_n_o(prog_n_o), .cclk_o(cclk_o),
    .din_o(din_o), .busy_o(busy_o), .ok_o(ok_o), .timeout_o(timeout_o), .crc_err_o(crc_err_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // ---------------- byte source ----------------
  logic [7:0] src_q[$];
  always @(negedge clk) begin
    byte_valid_i = (src_q.size() != 0);
    byte_data_i  = (src_q.size() != 0) ? src_q[0] : 8'h00;
  end

  // ---------------- reference model ----------------
  // phases: 0 idle 1 program 2 wake 3 data 4 done-wait 5 ok 6 failed
  int   ph = 0, elapsed = 0, m_len = 0, m_cnt = 0;
  bit   m_tmo = 0, m_crc = 0;
  bit   bit_busy = 0, bit_high = 0, m_cclk = 0, m_din = 0;
  int   bit_ctr = 0, bits_left = 0;
  logic [7:0] pend;
  logic [7:0] sent_q[$];
  int   rises = 0;

  function automatic bit m_ready();
    return ph == 3 && !bit_busy && m_cnt != m_len && (init_n_i || done_i);
  endfunction

  task automatic model_step();
    int  nx;
    bit  ld;
    logic [7:0] lb;
    int  ln;
    nx = ph; ld = 0; lb = 8'h00; ln = 0;
    case (ph)
      0, 5, 6: if (start_i) begin
        nx = 1; m_len = int'(length_i); m_cnt = 0; m_tmo = 0; m_crc = 0;
        sent_q.delete(); rises = 0;
      end
      1: if (!init_n_i) nx = 2;
         else if (elapsed == WAIT-1) begin nx = 6; m_tmo = 1; end
      2: if (init_n_i) nx = 3;
         else if (elapsed == WAIT-1) begin nx = 6; m_tmo = 1; end
      3: if (!bit_busy) begin
        if (m_cnt == m_len) nx = 4;
        else if (!init_n_i && !done_i) begin nx = 6; m_crc = 1; end
        else if (byte_valid_i) begin
          ld = 1; lb = byte_data_i; ln = 8; m_cnt++;
          sent_q.push_back(byte_data_i);
          void'(src_q.pop_front());
        end
      end
      4: if (!bit_busy && done_i) nx = 5;
         else if (elapsed == WAIT-1) begin nx = 6; m_tmo = 1; end
         else if (!bit_busy) begin ld = 1; lb = 8'hFF; ln = 1; end
      default: nx = 0;
    endcase
    if (nx != ph || !(ph == 1 || ph == 2 || ph == 4)) elapsed = 0;
    else elapsed++;
    if (nx == 6 && ph != 6) begin
      bit_busy = 0; bit_high = 0; m_cclk = 0; m_din = 0;
    end else if (ld) begin
      bit_busy = 1; bit_high = 0; bit_ctr = 0; m_cclk = 0;
      m_din = lb[7]; pend = lb << 1; bits_left = ln;
    end else if (bit_busy) begin
      if (bit_ctr == DIV-1) begin
        bit_ctr = 0;
        if (!bit_high) begin
          m_cclk = 1; bit_high = 1; bits_left--;
        end else begin
          m_cclk = 0; bit_high = 0;
          if (bits_left == 0) bit_busy = 0;
          else begin m_din = pend[7]; pend = pend << 1; end
        end
      end else bit_ctr++;
    end
    ph = nx;
  endtask

  task automatic model_reset();
    ph = 0; elapsed = 0; m_len = 0; m_cnt = 0; m_tmo = 0; m_crc = 0;
    bit_busy = 0; bit_high = 0; m_cclk = 0; m_din = 0; bit_ctr = 0; bits_left = 0;
  endtask

  // ---------------- per-cycle comparison and serial capture ----------------
  logic       prev_cclk = 1'b0;
  logic [7:0] rx_byte = '0;
  int         rx_bits = 0;
  int         rx_ok = 0;

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else model_step();
    #2;
    if (rst_n) begin
      chk("R2 prog_n_o", int'(prog_n_o), int'(ph != 1));
      chk("R6 byte_ready_o", int'(byte_ready_o), int'(m_ready()));
      chk("R5 cclk_o", int'(cclk_o), int'(m_cclk));
      chk("R5 din_o", int'(din_o), int'(m_din));
      chk("R11 busy_o", int'(busy_o), int'(ph >= 1 && ph <= 4));
      chk("R8 ok_o", int'(ok_o), int'(ph == 5));
      chk("R4 timeout_o", int'(timeout_o), int'(ph == 6 && m_tmo));
      chk("R7 crc_err_o", int'(crc_err_o), int'(ph == 6 && m_crc));
      if (cclk_o && !prev_cclk) begin
        rises++;
        if (sent_q.size() != 0) begin
          rx_byte = {rx_byte[6:0], din_o};
          rx_bits++;
          if (rx_bits == 8) begin
            chk("R5 msb-first byte", int'(rx_byte), int'(sent_q[0]));
            void'(sent_q.pop_front());
            rx_bits = 0;
            rx_ok++;
          end
        end
      end
      prev_cclk = cclk_o;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start(input int len);
    @(negedge clk); start_i = 1'b1; length_i = LW'(len);
    @(negedge clk); start_i = 1'b0;
  endtask

  task automatic wait_prog_release();
    for (int i = 0; i < 200 && !prog_n_o; i++) @(negedge clk);
  endtask

  task automatic wait_not_busy();
    for (int i = 0; i < 2000 && busy_o; i++) @(negedge clk);
  endtask

  task automatic handshake();
    cycles(3); init_n_i = 1'b0;
    wait_prog_release();
    cycles(4); init_n_i = 1'b1;
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R1 watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  // ---------------- scenarios ----------------
  initial begin
    int rx_before;
    // R1: reset state
    cycles(3);
    chk("R1 prog_n_o in reset", int'(prog_n_o), 1);
    chk("R1 cclk_o in reset", int'(cclk_o), 0);
    chk("R1 din_o in reset", int'(din_o), 0);
    chk("R1 status in reset", int'({byte_ready_o, busy_o, ok_o, timeout_o, crc_err_o}), 0);
    rst_n = 1'b1;
    cycles(3);
    chk("R1 idle after reset", int'({busy_o, ok_o, prog_n_o}), 1);

    // R2 R3 R5 R8 R11: normal three-byte load, stray start mid-load
    pulse_start(3);
    chk("R2 prog driven", int'(prog_n_o), 0);
    handshake();
    chk("R3 no data before init high", int'(rises), 0);
    src_q.push_back(8'hA5); src_q.push_back(8'h3C); src_q.push_back(8'h81);
    cycles(20);
    pulse_start(7);
    cycles(90);
    done_i = 1'b1;
    wait_not_busy();
    cycles(2);
    chk("R8 load completes ok", int'(ok_o), 1);
    chk("R5 bytes received", rx_ok, 3);
    chk("R11 start ignored, bytes taken", int'(src_q.size()), 0);
    done_i = 1'b0;

    // R4: no init low -> program wait times out
    pulse_start(1);
    cycles(WAIT + 5);
    chk("R4 program wait timeout", int'(timeout_o), 1);
    chk("R9 quiet after abort", int'({busy_o, prog_n_o, cclk_o}), 3'b010);

    // R4: init never returns high -> wake wait times out
    pulse_start(1);
    cycles(2); init_n_i = 1'b0;
    cycles(WAIT + 10);
    chk("R4 wake wait timeout", int'(timeout_o), 1);
    init_n_i = 1'b1;

    // R7: fault with done high is not an error; fault with done low is
    rx_before = rx_ok;
    pulse_start(3);
    handshake();
    src_q.push_back(8'h5A); src_q.push_back(8'hC3);
    cycles(80);
    done_i = 1'b1; init_n_i = 1'b0;
    cycles(5);
    chk("R7 no fault with done high", int'({busy_o, crc_err_o}), 2'b10);
    done_i = 1'b0;
    cycles(4);
    chk("R7 fault flagged", int'(crc_err_o), 1);
    chk("R9 crc not timeout", int'(timeout_o), 0);
    chk("R7 two bytes before fault", rx_ok - rx_before, 2);
    init_n_i = 1'b1;
    cycles(3);
    chk("R9 status held", int'(crc_err_o), 1);

    // R4 R8: done never rises -> done wait times out
    pulse_start(1);
    handshake();
    src_q.push_back(8'hF0);
    cycles(WAIT + 60);
    chk("R4 done wait timeout", int'(timeout_o), 1);
    chk("R9 clock low after abort", int'(cclk_o), 0);

    // R10: zero length, done already high
    done_i = 1'b1;
    pulse_start(0);
    handshake();
    wait_not_busy();
    chk("R10 empty load ok", int'(ok_o), 1);
    chk("R10 no data clocks", rises, 0);

    // R4 boundary: init falls in the last window cycle -> advance
    pulse_start(0);
    cycles(WAIT - 1); init_n_i = 1'b0;
    cycles(2);
    chk("R4 last-cycle condition wins", int'({busy_o, timeout_o}), 2'b10);
    init_n_i = 1'b1;
    wait_not_busy();
    chk("R4 boundary run ends ok", int'(ok_o), 1);

    // R4 boundary: one cycle later -> timeout
    pulse_start(0);
    cycles(WAIT); init_n_i = 1'b0;
    cycles(2);
    chk("R4 one cycle late times out", int'(timeout_o), 1);
    init_n_i = 1'b1; done_i = 1'b0;
    cycles(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule